// File: doc/BRIEF.md
# Two-Level Interrupt Mask and Arbiter

This block decides, on behalf of a processor core, whether an interrupt is taken and which source wins. It watches one high-priority request line and a vector of maskable request lines. Each maskable line has its own local enable. It also watches a strobe from the core that marks the end of an instruction. It holds two mask bits: X guards the high-priority line and I guards every maskable line. Both bits go out to the core. When a request is eligible while the strobe is high, the block raises a one-cycle take pulse. In the same cycle it gives the winner's index and a flag that tells whether the high-priority line won.

The X bit is set at reset. Software can clear X but can never set it again, so once initialization has cleared X the high-priority line cannot be masked. X is set again only by hardware. Entry for a high-priority interrupt sets both X and I. Entry for a maskable interrupt sets only I. A restore path loads both bits from the condition byte that the core pulls back on return. The high-priority request may be asynchronous and passes through a two-flop synchronizer before arbitration.

The block carries no data stream. Every pin is a plain control or status level, so there is no valid/ready handshake and no back-pressure.

Top module: `irq_mask_arb`

## Requirements
- R1: While reset is asserted, and after it is released, both mask bits read 1 (mask_x_o=1, mask_ibit_o=1) until something changes them.
- R2: A software write (sw_wr_i=1) sets X to the old X ANDed with sw_x_i. Writing 0 clears X, and writing 1 never sets it. The write loads I with sw_ibit_i.
- R3: Maskable line k is eligible only when mreq_i[k]=1, men_i[k]=1 and I=0.
- R4: The synchronized high-priority request is eligible whenever X=0, whatever the value of I.
- R5: If the high-priority line is eligible, it wins over every maskable line. In that case win_hp_o=1 and win_idx_o=0.
- R6: take_o is high in a cycle exactly when boundary_i=1 and at least one request is eligible. take_o is combinational from that cycle's inputs and the registered state, so no interrupt is taken while boundary_i=0.
- R7: A maskable entry (take_o=1, win_hp_o=0) sets I at the clock edge and leaves X unchanged.
- R8: A high-priority entry (take_o=1, win_hp_o=1) sets both X and I at the clock edge.
- R9: Among eligible maskable lines, the lowest index wins, and win_idx_o gives that index in binary.
- R10: A rise on hp_req_i can make take_o high only after two rising clock edges have sampled it.
- R11: A restore (rstr_i=1) loads X from rstr_x_i and I from rstr_ibit_i, and it may set X. In a single cycle, entry takes precedence over restore, and restore takes precedence over a software write. Eligibility in that cycle uses the mask values held before the edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| hp_req_i | input | 1 | High-priority request level, may be asynchronous |
| mreq_i | input | NSRC | Maskable request lines |
| men_i | input | NSRC | Local enable per maskable line |
| boundary_i | input | 1 | Instruction-completion strobe from the core |
| sw_wr_i | input | 1 | Software write of the mask bits |
| sw_x_i | input | 1 | Written X value (clearing only) |
| sw_ibit_i | input | 1 | Written I value |
| rstr_i | input | 1 | Restore of the mask bits on return |
| rstr_x_i | input | 1 | Restored X value |
| rstr_ibit_i | input | 1 | Restored I value |
| take_o | output | 1 | Take-interrupt pulse |
| win_idx_o | output | IW | Index of the winning maskable line |
| win_hp_o | output | 1 | Winner is the high-priority line |
| mask_x_o | output | 1 | Current X mask bit |
| mask_ibit_o | output | 1 | Current I mask bit |

## Verification
A software write of the mask bits can land in the same cycle as an instruction boundary that takes an interrupt. The bench provokes this in two ways. First, it clears I by a write while a maskable request waits at a boundary. The take must not happen that cycle, because the old I still holds, and it must happen on the next boundary. Second, it writes X=0 and I=0 in the same cycle as a high-priority entry. The masks read afterward must show the entry setting both bits, with no effect from the write.

// File: rtl/irq_pkg.sv
package irq_pkg;

  typedef struct packed {
    logic x;
    logic i;
  } mask_t;

  typedef enum logic [1:0] {
    UPD_NONE  = 2'd0,
    UPD_SW    = 2'd1,
    UPD_RSTR  = 2'd2,
    UPD_ENTRY = 2'd3
  } upd_e;

  localparam mask_t MASK_RESET = '{x: 1'b1, i: 1'b1};

endpackage

// File: rtl/irq_sync.sv
module irq_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] chain_q;

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain_q[0] <= 1'b0;
          else        chain_q[0] <= d_i;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain_q[s] <= 1'b0;
          else        chain_q[s] <= chain_q[s-1];
        end
      end
    end
  endgenerate

  assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/irq_prio.sv
module irq_prio #(
  parameter int N  = 8,
  parameter int IW = 3
) (
  input  logic [N-1:0]  req_i,
  output logic          any_o,
  output logic [IW-1:0] idx_o
);
  always_comb begin
    any_o = 1'b0;
    idx_o = '0;
    for (int k = N - 1; k >= 0; k--) begin
      if (req_i[k]) begin
        any_o = 1'b1;
        idx_o = IW'(k);
      end
    end
  end
endmodule

// File: rtl/irq_mask_regs.sv
module irq_mask_regs
  import irq_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  take_i,
  input  logic  take_hp_i,
  input  logic  sw_wr_i,
  input  logic  sw_x_i,
  input  logic  sw_ibit_i,
  input  logic  rstr_i,
  input  logic  rstr_x_i,
  input  logic  rstr_ibit_i,
  output mask_t mask_o
);
  mask_t mask_q, mask_d;
  upd_e  upd;

  always_comb begin
    if (take_i)       upd = UPD_ENTRY;
    else if (rstr_i)  upd = UPD_RSTR;
    else if (sw_wr_i) upd = UPD_SW;
    else              upd = UPD_NONE;
  end

  always_comb begin
    mask_d = mask_q;
    unique case (upd)
      UPD_ENTRY: begin
        mask_d.i = 1'b1;
        mask_d.x = mask_q.x | take_hp_i;
      end
      UPD_RSTR: begin
        mask_d.x = rstr_x_i;
        mask_d.i = rstr_ibit_i;
      end
      UPD_SW: begin
        mask_d.x = mask_q.x & sw_x_i;
        mask_d.i = sw_ibit_i;
      end
      default: mask_d = mask_q;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) mask_q <= MASK_RESET;
    else        mask_q <= mask_d;
  end

  assign mask_o = mask_q;
endmodule

// File: rtl/irq_mask_arb.sv
module irq_mask_arb
  import irq_pkg::*;
#(
  parameter int NSRC        = 8,
  parameter int SYNC_STAGES = 2,
  localparam int IW         = (NSRC > 1) ? $clog2(NSRC) : 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            hp_req_i,
  input  logic [NSRC-1:0] mreq_i,
  input  logic [NSRC-1:0] men_i,
  input  logic            boundary_i,
  input  logic            sw_wr_i,
  input  logic            sw_x_i,
  input  logic            sw_ibit_i,
  input  logic            rstr_i,
  input  logic            rstr_x_i,
  input  logic            rstr_ibit_i,
  output logic            take_o,
  output logic [IW-1:0]   win_idx_o,
  output logic            win_hp_o,
  output logic            mask_x_o,
  output logic            mask_ibit_o
);
  logic            hp_sync;
  logic            hp_elig;
  logic [NSRC-1:0] m_elig;
  logic            m_any;
  logic [IW-1:0]   m_idx;
  mask_t           mask;

  irq_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d_i   (hp_req_i),
    .q_o   (hp_sync)
  );

  assign hp_elig = hp_sync & ~mask.x;
  assign m_elig  = mreq_i & men_i & {NSRC{~mask.i}};

  irq_prio #(.N(NSRC), .IW(IW)) u_prio (
    .req_i (m_elig),
    .any_o (m_any),
    .idx_o (m_idx)
  );

  assign take_o    = boundary_i & (hp_elig | m_any);
  assign win_hp_o  = hp_elig;
  assign win_idx_o = hp_elig ? '0 : m_idx;

  irq_mask_regs u_regs (
    .clk         (clk),
    .rst_n       (rst_n),
    .take_i      (take_o),
    .take_hp_i   (hp_elig),
    .sw_wr_i     (sw_wr_i),
    .sw_x_i      (sw_x_i),
    .sw_ibit_i   (sw_ibit_i),
    .rstr_i      (rstr_i),
    .rstr_x_i    (rstr_x_i),
    .rstr_ibit_i (rstr_ibit_i),
    .mask_o      (mask)
  );

  assign mask_x_o    = mask.x;
  assign mask_ibit_o = mask.i;
endmodule

// File: rtl/irq_mask_arb_chk.sv
module irq_mask_arb_chk #(
  parameter int NSRC = 8,
  parameter int IW   = 3
) (
  input logic            clk,
  input logic            rst_n,
  input logic [NSRC-1:0] mreq_i,
  input logic [NSRC-1:0] men_i,
  input logic            boundary_i,
  input logic            sw_wr_i,
  input logic            rstr_i,
  input logic            take_o,
  input logic [IW-1:0]   win_idx_o,
  input logic            win_hp_o,
  input logic            mask_x_o,
  input logic            mask_ibit_o
);
  a_r1_reset_masks: assert property (@(posedge clk)
    !rst_n |=> (mask_x_o && mask_ibit_o));

  a_r2_x_never_set_by_sw: assert property (@(posedge clk) disable iff (!rst_n)
    (sw_wr_i && !rstr_i && !take_o && !mask_x_o) |=> !mask_x_o);

  a_r3_maskable_eligible: assert property (@(posedge clk) disable iff (!rst_n)
    (take_o && !win_hp_o) |-> (!mask_ibit_o && mreq_i[win_idx_o] && men_i[win_idx_o]));

  a_r4_hp_needs_x_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (take_o && win_hp_o) |-> !mask_x_o);

  a_r6_only_at_boundary: assert property (@(posedge clk) disable iff (!rst_n)
    take_o |-> boundary_i);

  a_r7_maskable_entry: assert property (@(posedge clk) disable iff (!rst_n)
    (take_o && !win_hp_o) |=> (mask_ibit_o && (mask_x_o == $past(mask_x_o))));

  a_r8_hp_entry: assert property (@(posedge clk) disable iff (!rst_n)
    (take_o && win_hp_o) |=> (mask_x_o && mask_ibit_o));

  a_r9_lowest_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (take_o && !win_hp_o) |->
      ((mreq_i & men_i & ((NSRC'(1) << win_idx_o) - NSRC'(1))) == '0));
endmodule

bind irq_mask_arb irq_mask_arb_chk #(.NSRC(NSRC), .IW(IW)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .mreq_i      (mreq_i),
  .men_i       (men_i),
  .boundary_i  (boundary_i),
  .sw_wr_i     (sw_wr_i),
  .rstr_i      (rstr_i),
  .take_o      (take_o),
  .win_idx_o   (win_idx_o),
  .win_hp_o    (win_hp_o),
  .mask_x_o    (mask_x_o),
  .mask_ibit_o (mask_ibit_o)
);

// File: tb/sim_irq_mask_arb.sv
module sim_irq_mask_arb;
  localparam int N  = 4;
  localparam int IW = 2;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          hp_req = 1'b0;
  logic [N-1:0]  mreq = '0, men = '0;
  logic          boundary = 1'b0;
  logic          sw_wr = 1'b0, sw_x = 1'b0, sw_ibit = 1'b0;
  logic          rstr = 1'b0, rstr_x = 1'b0, rstr_ibit = 1'b0;
  logic          take, win_hp, mx, mi;
  logic [IW-1:0] win_idx;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  always #10 clk = ~clk;

  irq_mask_arb #(.NSRC(N), .SYNC_STAGES(2)) u0 (
    .clk(clk), .rst_n(rst_n), .hp_req_i(hp_req), .mreq_i(mreq), .men_i(men),
    .boundary_i(boundary), .sw_wr_i(sw_wr), .sw_x_i(sw_x), .sw_ibit_i(sw_ibit),
    .rstr_i(rstr), .rstr_x_i(rstr_x), .rstr_ibit_i(rstr_ibit),
    .take_o(take), .win_idx_o(win_idx), .win_hp_o(win_hp),
    .mask_x_o(mx), .mask_ibit_o(mi)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic restore(input bit x, input bit i);
    rstr = 1'b1; rstr_x = x; rstr_ibit = i;
    @(negedge clk);
    rstr = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    #5;
    chk(mx == 1'b1 && mi == 1'b1, "R1 reset masks", {mx, mi}, 3);
    rst_n = 1'b1;
    @(negedge clk); #5;
    chk(mx == 1'b1 && mi == 1'b1, "R1 after release", {mx, mi}, 3);
    @(negedge clk);

    // R2: clear X, then try to set it again
    sw_wr = 1'b1; sw_x = 1'b0; sw_ibit = 1'b1;
    @(negedge clk);
    chk(mx == 1'b0, "R2 sw clears X", mx, 0);
    sw_x = 1'b1; sw_ibit = 1'b0;
    @(negedge clk);
    chk(mx == 1'b0, "R2 sw set of X ignored", mx, 0);
    chk(mi == 1'b0, "R2 sw writes I", mi, 0);
    sw_wr = 1'b0;

    // R11: restore may set X
    restore(1'b1, 1'b0);
    chk(mx == 1'b1 && mi == 1'b0, "R11 restore sets X", {mx, mi}, 2);

    // Exhaustive sweep: hp level, X, I, boundary, request, enable
    for (int hp = 0; hp < 2; hp++) begin
      hp_req = hp[0];
      repeat (3) @(negedge clk);
      for (int x = 0; x < 2; x++)
        for (int i = 0; i < 2; i++)
          for (int b = 0; b < 2; b++)
            for (int v = 0; v < 256; v++) begin
              automatic bit          hp_e, any, tk, ex_x;
              automatic int          lo = 0;
              automatic logic [N-1:0] el;
              restore(x[0], i[0]);
              mreq = v[3:0]; men = v[7:4]; boundary = b[0];
              el   = v[3:0] & v[7:4] & {N{~i[0]}};
              hp_e = hp[0] & ~x[0];
              any  = (el != '0);
              for (int k = N - 1; k >= 0; k--) if (el[k]) lo = k;
              tk   = b[0] & (hp_e | any);
              #5;
              chk(take == tk, "R3/R4/R6 take", take, tk);
              if (tk) begin
                chk(win_hp == hp_e, "R5 hp wins", win_hp, hp_e);
                chk(int'(win_idx) == (hp_e ? 0 : lo), "R9 lowest index", win_idx, hp_e ? 0 : lo);
              end
              @(negedge clk);
              boundary = 1'b0;
              ex_x = tk ? (x[0] | hp_e) : x[0];
              chk(mx == ex_x, tk && hp_e ? "R8 X after entry" : "R7 X after entry", mx, ex_x);
              chk(mi == (tk ? 1'b1 : i[0]), "R7/R8 I after entry", mi, tk ? 1 : i);
            end
    end

    // R10: two-edge synchronizer delay
    hp_req = 1'b0; mreq = '0; men = '0;
    repeat (3) @(negedge clk);
    restore(1'b0, 1'b1);
    boundary = 1'b1; hp_req = 1'b1;
    #5;
    chk(take == 1'b0, "R10 no take before sampling", take, 0);
    @(negedge clk); #5;
    chk(take == 1'b0, "R10 no take after one edge", take, 0);
    @(negedge clk); #5;
    chk(take == 1'b1 && win_hp == 1'b1, "R10 take after two edges", take, 1);
    @(negedge clk);
    boundary = 1'b0;

    // R11 same cycle: write clearing I while a maskable request waits
    hp_req = 1'b0;
    repeat (3) @(negedge clk);
    restore(1'b1, 1'b1);
    mreq = 4'b0100; men = 4'b0100; boundary = 1'b1;
    sw_wr = 1'b1; sw_x = 1'b1; sw_ibit = 1'b0;
    #5;
    chk(take == 1'b0, "R11 old I still masks", take, 0);
    @(negedge clk);
    sw_wr = 1'b0;
    #5;
    chk(take == 1'b1 && win_idx == 2'd2, "R11 take on next boundary", take, 1);
    @(negedge clk);
    boundary = 1'b0;
    chk(mi == 1'b1, "R7 I set after delayed entry", mi, 1);

    // R11 same cycle: hp entry beats a write of X=0,I=0
    hp_req = 1'b1; mreq = '0; men = '0;
    repeat (3) @(negedge clk);
    restore(1'b0, 1'b0);
    boundary = 1'b1; sw_wr = 1'b1; sw_x = 1'b0; sw_ibit = 1'b0;
    #5;
    chk(take == 1'b1 && win_hp == 1'b1, "R11 hp entry with write", take, 1);
    @(negedge clk);
    boundary = 1'b0; sw_wr = 1'b0;
    chk(mx == 1'b1 && mi == 1'b1, "R11 entry beats write", {mx, mi}, 3);

    // R11: entry beats restore in the same cycle
    restore(1'b0, 1'b0);
    boundary = 1'b1; rstr = 1'b1; rstr_x = 1'b0; rstr_ibit = 1'b0;
    @(negedge clk);
    boundary = 1'b0; rstr = 1'b0;
    chk(mx == 1'b1 && mi == 1'b1, "R11 entry beats restore", {mx, mi}, 3);

    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end
endmodule